// File: doc/BRIEF.md
# Displaced 32-bit Pointer Store Unit

This unit executes one family of store operations: a 32-bit pointer register is written to memory at an address formed from another pointer register plus a signed 8-bit offset. It keeps four 32-bit pointer registers, numbered 0 to 3. A byte stream supplies three bytes in order: a prefix, an operation byte that names the source and base registers, and a displacement. The unit decodes them, forms the effective address and decides whether that address is logical or physical. It then issues four single-byte writes on a plain memory write port, with the least significant byte first. A separate output marks each write as logical, meaning it still needs address translation downstream.

Timing is fixed. The clock after the prefix is accepted is clock 1, and the operation takes 19 clocks split into phases of 2, 2, 2, 1, 3, 3, 3 and 3 clocks. The controller moves through the states IDLE, PFX, OPC, DSP, ADR and WR. The transitions are:
- IDLE to PFX when a valid prefix is seen.
- PFX to OPC after 2 clocks.
- OPC to DSP after 2 clocks if the operation byte is legal; OPC to IDLE if it is not.
- DSP to ADR after 2 clocks.
- ADR to WR after 1 clock.
- WR to WR between the four 3-clock byte phases.
- WR to IDLE after the fourth byte phase.

The fetch side presents the operation byte during clocks 1 to 4 and the displacement byte during clocks 5 and 6. A physical address keeps its low 20 or 24 bits, chosen by a mode input.

Top module: `ptr_disp_store`

## Requirements
- R1: After reset, `busy`, `mem_we`, `illegal` and `mem_logical` are low.
- R2: In IDLE, a byte 0x6D with `in_valid` high starts an operation. The operation byte is sampled at the end of clock 4 and is legal when its bits [3:0] are 4'b1001. Its bits [7:6] select the source register and bits [5:4] select the base register, with codes 00, 01, 10 and 11 meaning registers 0, 1, 2 and 3. `illegal` stays low for a legal operation.
- R3: The displacement is sampled at the end of clock 6. It is sign-extended and added to the base register to form the effective address EA.
- R4: Byte write k (k = 0 to 3) carries source bits [8k+7:8k] to address EA+k.
- R5: `busy` is high in clocks 1 to 19 and low from clock 20. Byte phase k covers clocks 8+3k to 10+3k. During a phase, `mem_addr` and `mem_data` hold steady, and `mem_we` is high only in the last clock of the phase (clocks 10, 13, 16 and 19).
- R6: If bits [31:16] of the base register are all ones, `mem_logical` is high during the byte phases. The address is then EA+k modulo 2^32.
- R7: Otherwise `mem_logical` is low and the address is EA+k with the mask applied after the increment. The mask keeps the low 20 bits when `phys_wide` is 0 and the low 24 bits when it is 1. `phys_wide` is sampled in clock 7.
- R8: When the source and base fields name the same register, that register's value from before the operation is used both as the stored data and as the base.
- R9: A register load (`ld_en`) is applied at the clock edge when `busy` is low and is ignored while `busy` is high.
- R10: `in_valid` while `busy` is high starts nothing: `busy` falls at clock 20 even if 0x6D is offered in every clock.
- R11: In IDLE, a valid byte other than 0x6D raises `illegal` in the next clock only. `busy` stays low and nothing is written.
- R12: An illegal operation byte raises `illegal` in clock 5 only. `busy` is low from clock 5, and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Offers a starting byte on `in_byte` |
| in_byte | input | 8 | Instruction byte stream |
| phys_wide | input | 1 | Physical address width: 0 for 20 bits, 1 for 24 bits |
| ld_en | input | 1 | Pointer register load strobe |
| ld_sel | input | 2 | Pointer register selected for the load |
| ld_val | input | 32 | Value to load |
| busy | output | 1 | An operation is in progress |
| illegal | output | 1 | One-clock strobe for a rejected byte |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | 32 | Byte write address |
| mem_data | output | 8 | Byte write data |
| mem_logical | output | 1 | The current write address needs translation |

## Verification
Stores are issued with a positive offset, with an offset of -128, and from a base whose upper half is all ones, positioned so that EA+k crosses 2^32. These patterns separate the sign-extension path from the logical wrap. Two more stores start from a base just under the 20-bit boundary, once in each width mode. They show whether the mask is applied after the increment and whether the mode is honoured. Further runs cover:
- the same register used as source and base;
- a register load issued in the middle of an operation, with its effect on a later store;
- a start byte held valid through the whole operation;
- a missing prefix;
- a bad operation nibble.

Together these separate accepted inputs from ignored ones.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam logic [7:0] PREFIX_CODE  = 8'h6D;
    localparam logic [3:0] OPC_LOW_CODE = 4'h9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PFX,
        S_OPC,
        S_DSP,
        S_ADR,
        S_WR
    } psd_state_t;

    // Index of the final clock of each phase (phase length minus one).
    function automatic logic [1:0] phase_last(input psd_state_t s);
        unique case (s)
            S_PFX, S_OPC, S_DSP: phase_last = 2'd1;
            S_WR:                phase_last = 2'd2;
            default:             phase_last = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/psd_ptr_file.sv
module psd_ptr_file #(
    parameter int PTR_W   = 32,
    parameter int NUM_PTR = 4,
    localparam int SEL_W  = $clog2(NUM_PTR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [PTR_W-1:0] ld_val,
    input  logic [SEL_W-1:0] rd_a_sel,
    output logic [PTR_W-1:0] rd_a,
    input  logic [SEL_W-1:0] rd_b_sel,
    output logic [PTR_W-1:0] rd_b
);

    logic [NUM_PTR-1:0][PTR_W-1:0] regs_q;

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (ld_en && !lock && (ld_sel == SEL_W'(i))) begin
                regs_q[i] <= ld_val;
            end
        end
    end

    assign rd_a = regs_q[rd_a_sel];
    assign rd_b = regs_q[rd_b_sel];

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && ld_en) |=> (regs_q == $past(regs_q)));  // R9

endmodule

// File: rtl/psd_op_decode.sv
module psd_op_decode #(
    parameter int NUM_PTR = 4,
    localparam int SEL_W  = $clog2(NUM_PTR)
) (
    input  logic [7:0]       op_byte,
    output logic             legal,
    output logic [SEL_W-1:0] src_sel,
    output logic [SEL_W-1:0] base_sel
);
    import psd_pkg::*;

    always_comb begin
        legal    = (op_byte[3:0] == OPC_LOW_CODE);
        src_sel  = op_byte[7 -: SEL_W];
        base_sel = op_byte[5 -: SEL_W];
    end

endmodule

// File: rtl/psd_addr_gen.sv
module psd_addr_gen #(
    parameter int PTR_W       = 32,
    parameter int IDX_W       = 2,
    parameter int PHYS_NARROW = 20,
    parameter int PHYS_WIDE   = 24
) (
    input  logic [PTR_W-1:0] ea,
    input  logic [IDX_W-1:0] idx,
    input  logic             logical,
    input  logic             wide,
    output logic [PTR_W-1:0] addr
);

    localparam logic [PTR_W-1:0] NARROW_MASK = (PTR_W'(1) << PHYS_NARROW) - PTR_W'(1);
    localparam logic [PTR_W-1:0] WIDE_MASK   = (PTR_W'(1) << PHYS_WIDE) - PTR_W'(1);

    logic [PTR_W-1:0] sum;

    always_comb begin
        sum  = ea + {{(PTR_W-IDX_W){1'b0}}, idx};
        addr = logical ? sum : (sum & (wide ? WIDE_MASK : NARROW_MASK));
    end

endmodule

// File: rtl/ptr_disp_store.sv
module ptr_disp_store #(
    parameter int PTR_W       = 32,
    parameter int BYTE_W      = 8,
    parameter int NUM_PTR     = 4,
    parameter int TAG_W       = 16,
    parameter int PHYS_NARROW = 20,
    parameter int PHYS_WIDE   = 24,
    localparam int SEL_W      = $clog2(NUM_PTR),
    localparam int NBYTES     = PTR_W / BYTE_W,
    localparam int IDX_W      = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              phys_wide,
    input  logic              ld_en,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [PTR_W-1:0]  ld_val,
    output logic              busy,
    output logic              illegal,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0] mem_data,
    output logic              mem_logical
);
    import psd_pkg::*;

    psd_state_t       state_q, state_d;
    logic [1:0]       cnt_q, cnt_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             bad_d, illegal_q;

    logic             op_legal;
    logic [SEL_W-1:0] dec_src, dec_base;
    logic [SEL_W-1:0] src_q, base_q;
    logic [BYTE_W-1:0] disp_q;
    logic [PTR_W-1:0] src_val, base_val;
    logic [PTR_W-1:0] ea_q, data_q, wr_addr;
    logic             logical_q, wide_q;
    logic             phase_end;

    psd_op_decode #(.NUM_PTR(NUM_PTR)) u_dec (
        .op_byte  (in_byte),
        .legal    (op_legal),
        .src_sel  (dec_src),
        .base_sel (dec_base)
    );

    psd_ptr_file #(.PTR_W(PTR_W), .NUM_PTR(NUM_PTR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (busy),
        .ld_en    (ld_en),
        .ld_sel   (ld_sel),
        .ld_val   (ld_val),
        .rd_a_sel (src_q),
        .rd_a     (src_val),
        .rd_b_sel (base_q),
        .rd_b     (base_val)
    );

    psd_addr_gen #(
        .PTR_W(PTR_W), .IDX_W(IDX_W),
        .PHYS_NARROW(PHYS_NARROW), .PHYS_WIDE(PHYS_WIDE)
    ) u_addr (
        .ea      (ea_q),
        .idx     (idx_q),
        .logical (logical_q),
        .wide    (wide_q),
        .addr    (wr_addr)
    );

    assign phase_end = (cnt_q == phase_last(state_q));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cnt_q     <= '0;
            idx_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            idx_q     <= idx_d;
            illegal_q <= bad_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = phase_end ? 2'd0 : cnt_q + 2'd1;
        idx_d   = idx_q;
        bad_d   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                cnt_d = '0;
                idx_d = '0;
                if (in_valid) begin
                    if (in_byte == PREFIX_CODE) state_d = S_PFX;
                    else                        bad_d   = 1'b1;
                end
            end
            S_PFX: if (phase_end) state_d = S_OPC;
            S_OPC: if (phase_end) begin
                if (op_legal) state_d = S_DSP;
                else begin
                    state_d = S_IDLE;
                    bad_d   = 1'b1;
                end
            end
            S_DSP: if (phase_end) state_d = S_ADR;
            S_ADR: if (phase_end) state_d = S_WR;
            S_WR: if (phase_end) begin
                if (idx_q == IDX_W'(NBYTES - 1)) state_d = S_IDLE;
                else                             idx_d   = idx_q + IDX_W'(1);
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Datapath captures at the phase boundaries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q     <= '0;
            base_q    <= '0;
            disp_q    <= '0;
            ea_q      <= '0;
            data_q    <= '0;
            logical_q <= 1'b0;
            wide_q    <= 1'b0;
        end else begin
            if (state_q == S_OPC && phase_end) begin
                src_q  <= dec_src;
                base_q <= dec_base;
            end
            if (state_q == S_DSP && phase_end) begin
                disp_q <= in_byte;
            end
            if (state_q == S_ADR) begin
                ea_q      <= base_val + {{(PTR_W-BYTE_W){disp_q[BYTE_W-1]}}, disp_q};
                data_q    <= src_val;
                logical_q <= (base_val[PTR_W-1 -: TAG_W] == '1);
                wide_q    <= phys_wide;
            end
        end
    end

    // Outputs
    always_comb begin
        busy        = (state_q != S_IDLE);
        illegal     = illegal_q;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_data    = '0;
        mem_logical = 1'b0;
        if (state_q == S_WR) begin
            mem_we      = phase_end;
            mem_addr    = wr_addr;
            mem_data    = data_q[idx_q*BYTE_W +: BYTE_W];
            mem_logical = logical_q;
        end
    end

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);  // R5
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);  // R5
    AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR && cnt_q != 2'd0) |-> ($stable(mem_addr) && $stable(mem_data)));  // R5
    AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !mem_we));  // R11
    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (!illegal || $past(in_valid)));  // R12
    AST_PHYS_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_logical && !wide_q) |-> (mem_addr[PTR_W-1:PHYS_NARROW] == '0));  // R7
    AST_PHYS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_logical) |-> (mem_addr[PTR_W-1:PHYS_WIDE] == '0));  // R7

endmodule

// File: tb/sim_ptr_disp_store.sv
`timescale 1ns/1ps
module sim_ptr_disp_store;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        phys_wide = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [31:0] ld_val = '0;
    logic        busy, illegal, mem_we, mem_logical;
    logic [31:0] mem_addr;
    logic [7:0]  mem_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] m_reg [4];

    ptr_disp_store u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .phys_wide(phys_wide), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
        .busy(busy), .illegal(illegal), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_logical(mem_logical)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog (R5) actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_reg(logic [1:0] sel, logic [31:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_val = val;
        @(negedge clk);
        ld_en = 1'b0;
        m_reg[sel] = val;
    endtask

    // Full store with per-clock checks; expected values from the requirements.
    task automatic run_store(string tag, logic [7:0] op, logic [7:0] d,
                             bit ld_mid, logic [31:0] ld_v, bit spam);
        logic [31:0] srcv, basev, ea, a;
        bit lg;
        int k;
        srcv  = m_reg[op[7:6]];
        basev = m_reg[op[5:4]];
        ea    = basev + {{24{d[7]}}, d};
        lg    = (basev[31:16] == 16'hFFFF);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h6D;
        for (int c = 1; c <= 21; c++) begin
            @(negedge clk);
            if (c == 1) begin in_valid = spam; in_byte = op; end
            if (c == 5) in_byte = d;
            if (c == 7 && spam) in_byte = 8'h6D;
            if (c == 3 && ld_mid) begin ld_en = 1'b1; ld_sel = op[7:6]; ld_val = ld_v; end
            if (c == 4) ld_en = 1'b0;
            chk($sformatf("%s R5 busy c%0d", tag, c), 32'(busy), 32'(c <= 19));
            chk($sformatf("%s R5 we c%0d", tag, c), 32'(mem_we),
                32'(c == 10 || c == 13 || c == 16 || c == 19));
            if (c == 5) chk($sformatf("%s R2 illegal", tag), 32'(illegal), 32'd0);
            if (c >= 8 && c <= 19) begin
                k = (c - 8) / 3;
                a = ea + 32'(k);
                if (!lg) a = a & (phys_wide ? 32'h00FF_FFFF : 32'h000F_FFFF);
                chk($sformatf("%s R3/R6/R7 addr c%0d", tag, c), mem_addr, a);
                chk($sformatf("%s R4 data c%0d", tag, c), 32'(mem_data), 32'(srcv[8*k +: 8]));
                chk($sformatf("%s R6 logical c%0d", tag, c), 32'(mem_logical), 32'(lg));
            end
            if (c == 20) begin in_valid = 1'b0; in_byte = '0; end
        end
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 we", 32'(mem_we), 0);
        chk("R1 illegal", 32'(illegal), 0);
        chk("R1 logical", 32'(mem_logical), 0);
    endtask

    task automatic t_basic();      // R2 R3 R4: src reg1, base reg0, +16
        phys_wide = 1'b0;
        run_store("basic", 8'h49, 8'h10, 1'b0, '0, 1'b0);
    endtask

    task automatic t_negative();   // R3 R7: -128 offset, both widths
        phys_wide = 1'b0;
        run_store("neg20", 8'h19, 8'h80, 1'b0, '0, 1'b0);
        phys_wide = 1'b1;
        run_store("neg24", 8'h19, 8'h80, 1'b0, '0, 1'b0);
    endtask

    task automatic t_logical_wrap();  // R6: EA = FFFFFFFF, then wraps to 0
        phys_wide = 1'b0;
        run_store("logwrap", 8'hE9, 8'h01, 1'b0, '0, 1'b0);
    endtask

    task automatic t_phys_mask();  // R7: mask after increment at 20/24 bits
        phys_wide = 1'b0;
        run_store("mask20", 8'h79, 8'h01, 1'b0, '0, 1'b0);
        phys_wide = 1'b1;
        run_store("mask24", 8'h79, 8'h01, 1'b0, '0, 1'b0);
    endtask

    task automatic t_alias();      // R8: reg3 stored at reg3-1
        phys_wide = 1'b1;
        run_store("alias R8", 8'hF9, 8'hFF, 1'b0, '0, 1'b0);
    endtask

    task automatic t_busy_ignore(); // R9 R10: load and start bytes during busy
        phys_wide = 1'b1;
        run_store("midload R9 R10", 8'h09, 8'h04, 1'b1, 32'hDEAD_BEEF, 1'b1);
        run_store("after R9", 8'h09, 8'h04, 1'b0, '0, 1'b0);
        load_reg(2'd0, 32'h5555_AAAA);
        run_store("idleload R9", 8'h19, 8'h00, 1'b0, '0, 1'b0);
    endtask

    task automatic t_no_prefix();  // R11
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h6C;
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            if (c == 1) begin in_valid = 1'b0; in_byte = '0; end
            chk($sformatf("R11 illegal c%0d", c), 32'(illegal), 32'(c == 1));
            chk($sformatf("R11 busy c%0d", c), 32'(busy), 0);
            chk($sformatf("R11 we c%0d", c), 32'(mem_we), 0);
        end
    endtask

    task automatic t_bad_op();     // R12: low nibble 8 instead of 9
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h6D;
        for (int c = 1; c <= 21; c++) begin
            @(negedge clk);
            if (c == 1) begin in_valid = 1'b0; in_byte = 8'h48; end
            if (c == 5) in_byte = '0;
            chk($sformatf("R12 illegal c%0d", c), 32'(illegal), 32'(c == 5));
            chk($sformatf("R12 busy c%0d", c), 32'(busy), 32'(c <= 4));
            chk($sformatf("R12 we c%0d", c), 32'(mem_we), 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        load_reg(2'd0, 32'h0004_1000);
        load_reg(2'd1, 32'hA1B2_C3D4);
        load_reg(2'd2, 32'hFFFF_FFFE);
        load_reg(2'd3, 32'h000F_FFFE);
        t_basic();
        t_negative();
        t_logical_wrap();
        t_phys_mask();
        t_alias();
        t_busy_ignore();
        t_no_prefix();
        t_bad_op();
        t_basic();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule